// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous fast page mode DRAM array of 2^(2·MA_W) words, 40 bits each by default. The DRAM receives its address over MA_W multiplexed pins. The host offers one request at a time through a valid/ready handshake. Each request carries a direction, a word address and write data. Reads are answered with a single-cycle response pulse that carries the sampled word. The controller drives the active-low row strobe, column strobe, write enable and output enable, the multiplexed address, the write data and a drive enable for the shared data bus. All strobes and the address leave from registers.

After reset the controller waits out a power-up interval. It then issues a burst of column-before-row refreshes, and only after that does it accept host traffic. From then on an internal interval timer requests one refresh per period, and a pending refresh takes priority over new host requests. Every access is an early write or a plain read. A row stays open after an access. A later request to the same row is served as a page-mode column access. A request to another row closes the page, precharges and opens the new row. A page is also closed when the row-strobe low time would exceed its limit. Every timing limit is a parameter counted in clock cycles, so one netlist serves different speed grades and clock rates.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, all four strobes are high, the data-bus enable is low, req_ready is low and rsp_valid is low.
- R2: No row strobe falls within T_INIT cycles of reset release, and at least N_INIT refresh cycles complete before req_ready is first high.
- R3: A refresh drops the column strobe at least T_CSR cycles before the row strobe falls. Write enable is high at the row-strobe fall, and the column strobe stays low until the row strobe rises again.
- R4: After initialization, two consecutive refresh row-strobe falls are never more than T_REFI + T_RCD + T_CAS + T_CP + T_RAS + T_RP + T_CSR + 4 cycles apart.
- R5: The word address is split so that its upper MA_W bits are the row, driven when the row strobe falls, and its lower MA_W bits are the column, driven when the column strobe falls. Accesses reach the array in the order the host issued them.
- R6: Row strobe high time is at least T_RP cycles. Row strobe low time is at least T_RAS and at most T_RASP_MAX cycles. For an access, the column strobe falls no sooner than T_RCD cycles after the row strobe. A long same-row run is split by closing the page.
- R7: A write is an early write: at the column-strobe fall, write enable is low, output enable is high and the bus enable is high. The column strobe is low for T_CAS cycles and then high for at least T_CP cycles.
- R8: A read has output enable low, write enable high and the bus enable low at the column-strobe fall. rsp_valid pulses for one cycle at the clock edge that ends the T_CAS-cycle column-strobe low window, and rsp_rdata then holds the word stored at that address.
- R9: A request to the open row causes no new activation. A request to a different row causes exactly one activation.
- R10: A request is taken at a clock edge where req_valid and req_ready are both high. req_ready is high only while the column strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | MA_W | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven toward the array |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the array |

## Verification
Every DRAM-side output changes at a rising edge, so the bench samples it at the following falling edge and measures strobe low and high times in whole cycles. A read result is due at the edge where the column strobe rises, exactly T_CAS cycles after it fell, so the bench checks the response in that same half cycle against the length of the low window it has just measured. Activation counts for a burst are read one falling edge after the last request is accepted. That is the edge where a new row, if one was opened, has already become visible. The array model in the bench stores writes and returns reads by the row and column it saw on the pins, so a wrong split of the address shows up as a wrong order or wrong data.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int MA_W       = 10,
  parameter int DATA_W     = 40,
  parameter int T_INIT     = 25000,
  parameter int N_INIT     = 8,
  parameter int T_REFI     = 1950,
  parameter int T_RP       = 7,
  parameter int T_RAS      = 9,
  parameter int T_RCD      = 4,
  parameter int T_CAS      = 5,
  parameter int T_CP       = 2,
  parameter int T_CSR      = 1,
  parameter int T_RASP_MAX = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int HA_W  = 2 * MA_W;
  localparam int CNT_W = $clog2(T_INIT + T_RP + T_RAS + T_RCD + T_CAS + T_CP + T_CSR + 1);
  localparam int AGE_W = $clog2(T_RASP_MAX + 2);
  localparam int REF_W = $clog2(T_REFI + 1);
  localparam int INI_W = $clog2(N_INIT + 1);

  typedef enum logic [2:0] {
    S_POWER, S_IDLE, S_CBR_CAS, S_CBR_RAS, S_ACT, S_COL, S_PAGE, S_PRE
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [AGE_W-1:0] ras_age;
  logic [REF_W-1:0] ref_tmr;
  logic [INI_W-1:0] init_left;
  logic             ref_pend, pend, op_wr;
  logic [MA_W-1:0]  cur_row, op_col;
  logic [DATA_W-1:0] op_data;

  wire cnt_z    = (cnt == '0);
  wire ref_need = ref_pend || (init_left != '0);
  wire in_page  = (st == S_PAGE);
  wire page_ok  = (int'(ras_age) + 1 + T_CAS + T_CP) <= T_RASP_MAX;
  wire may_close = (int'(ras_age) + 1) >= T_RAS;
  wire [MA_W-1:0] req_row = req_addr[HA_W-1:MA_W];
  wire [MA_W-1:0] req_col = req_addr[MA_W-1:0];
  wire row_hit = (req_row == cur_row);

  assign req_ready = (st == S_IDLE && !ref_need && !pend) ||
                     (in_page && cnt_z && !ref_pend && !pend && page_ok);
  wire take = req_valid && req_ready;

  wire              c_wr   = in_page ? req_write : op_wr;
  wire [MA_W-1:0]   c_col  = in_page ? req_col   : op_col;
  wire [DATA_W-1:0] c_data = in_page ? req_wdata : op_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_POWER;
      cnt         <= CNT_W'(T_INIT - 1);
      ras_age     <= '0;
      ref_tmr     <= REF_W'(T_REFI - 1);
      init_left   <= INI_W'(N_INIT);
      ref_pend    <= 1'b0;
      pend        <= 1'b0;
      op_wr       <= 1'b0;
      cur_row     <= '0;
      op_col      <= '0;
      op_data     <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_z) cnt <= cnt - 1'b1;

      if (dram_ras_n) ras_age <= '0;
      else if (ras_age != '1) ras_age <= ras_age + 1'b1;

      if (take) begin
        op_wr   <= req_write;
        op_col  <= req_col;
        op_data <= req_wdata;
        cur_row <= req_row;
      end

      case (st)
        S_POWER: if (cnt_z) st <= S_IDLE;
        S_IDLE: begin
          if (ref_need) begin
            ref_pend   <= 1'b0;
            if (init_left != '0) init_left <= init_left - 1'b1;
            dram_cas_n <= 1'b0;
            cnt        <= CNT_W'(T_CSR - 1);
            st         <= S_CBR_CAS;
          end else if (pend || req_valid) begin
            pend       <= 1'b0;
            dram_addr  <= pend ? cur_row : req_row;
            dram_ras_n <= 1'b0;
            cnt        <= CNT_W'(T_RCD - 1);
            st         <= S_ACT;
          end
        end
        S_CBR_CAS: if (cnt_z) begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(T_RAS - 1);
          st         <= S_CBR_RAS;
        end
        S_CBR_RAS: if (cnt_z) begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= 1'b1;
          cnt        <= CNT_W'(T_RP - 1);
          st         <= S_PRE;
        end
        S_ACT, S_PAGE: begin
          if (cnt_z && (st == S_ACT || (take && row_hit))) begin
            dram_cas_n  <= 1'b0;
            dram_addr   <= c_col;
            dram_we_n   <= !c_wr;
            dram_oe_n   <= c_wr;
            dram_dq_oe  <= c_wr;
            dram_dq_out <= c_data;
            cnt         <= CNT_W'(T_CAS - 1);
            st          <= S_COL;
          end else if (cnt_z && take) begin
            pend <= 1'b1;
          end else if (cnt_z && in_page && (ref_pend || pend || !page_ok) && may_close) begin
            dram_ras_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= S_PRE;
          end
        end
        S_COL: if (cnt_z) begin
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_oe_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!op_wr) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dq_in;
          end
          cnt <= CNT_W'(T_CP - 1);
          st  <= S_PAGE;
        end
        S_PRE: if (cnt_z) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (ref_tmr == '0) begin
        ref_tmr  <= REF_W'(T_REFI - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end
    end
  end

  assert_no_ready_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_left != '0) |-> !req_ready);
  assert_cbr_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> dram_we_n);
  assert_cbr_cas_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n));
  assert_ras_low_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (int'(ras_age) < T_RASP_MAX));
  assert_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));
  assert_rsp_at_cas_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(dram_cas_n));
  assert_ready_cas_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_cas_n);
endmodule

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
  localparam int MA_W = 3, DATA_W = 40;
  localparam int T_INIT = 40, N_INIT = 8, T_REFI = 120, T_RP = 3, T_RAS = 6;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_CSR = 2, T_RASP_MAX = 30;
  localparam int NW = 1 << (2 * MA_W);
  localparam int NC = 1 << MA_W;
  localparam int REF_BOUND = T_REFI + T_RCD + T_CAS + T_CP + T_RAS + T_RP + T_CSR + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2*MA_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, dram_dq_out, rd_bus;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [MA_W-1:0] dram_addr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .MA_W(MA_W), .DATA_W(DATA_W), .T_INIT(T_INIT), .N_INIT(N_INIT), .T_REFI(T_REFI),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_CSR(T_CSR), .T_RASP_MAX(T_RASP_MAX)
  ) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(rd_bus)
  );

  int checks = 0, fails = 0, wd = 0;
  int cyc = 0, ras_hi = 1000, ras_lo = 0, cas_hi = 1000, cas_lo = 0;
  int n_act = 0, n_ref = 0, last_ref = 0, first_ras = -1;
  bit p_ras = 1'b1, p_cas = 1'b1, in_ref = 1'b0, seen_ready = 1'b0;
  logic [MA_W-1:0] row_seen = '0;
  logic [DATA_W-1:0] mem [int];
  logic [DATA_W-1:0] expv [NW];
  int acc_q [$];

  initial rd_bus = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int s);
    return {8'(a * 29 + s * 7 + 3), 32'(a * 32'h9E3779B1 + s * 32'h01000193) ^ 32'hC3A50F1E};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        if (first_ras < 0) begin
          first_ras = cyc;
          chk(cyc > T_INIT, "R2", "first row strobe cycle", cyc, T_INIT + 1);
        end
        chk(ras_hi >= T_RP, "R6", "row precharge cycles", ras_hi, T_RP);
        if (!dram_cas_n) begin
          chk(cas_lo >= T_CSR, "R3", "column lead before refresh", cas_lo, T_CSR);
          chk(dram_we_n, "R3", "write enable at refresh", dram_we_n, 1);
          if (seen_ready) chk(cyc - last_ref <= REF_BOUND, "R4", "refresh gap", cyc - last_ref, REF_BOUND);
          last_ref = cyc;
          n_ref++;
          in_ref = 1'b1;
        end else begin
          in_ref = 1'b0;
          row_seen = dram_addr;
          n_act++;
        end
      end
      if (!p_ras && dram_ras_n) begin
        chk(ras_lo >= T_RAS, "R6", "row strobe low min", ras_lo, T_RAS);
        chk(ras_lo <= T_RASP_MAX, "R6", "row strobe low max", ras_lo, T_RASP_MAX);
        if (in_ref) chk(!p_cas, "R3", "column low through refresh", p_cas, 0);
      end
      if (p_cas && !dram_cas_n && !dram_ras_n) begin
        int key;
        key = int'({row_seen, dram_addr});
        chk(ras_lo >= T_RCD, "R6", "row to column delay", ras_lo, T_RCD);
        chk(cas_hi >= T_CP, "R7", "column precharge", cas_hi, T_CP);
        if (acc_q.size() == 0) chk(1'b0, "R5", "access without request", key, 0);
        else begin
          int e;
          e = acc_q.pop_front();
          chk(key == e, "R5", "row/column on pins", key, e);
        end
        if (!dram_we_n) begin
          chk(dram_oe_n && dram_dq_oe, "R7", "early write oe_n/bus enable", {dram_oe_n, dram_dq_oe}, 2'b11);
          mem[key] = dram_dq_out;
        end else begin
          chk(!dram_oe_n && !dram_dq_oe, "R8", "read oe_n/bus enable", {dram_oe_n, dram_dq_oe}, 2'b00);
          rd_bus = mem.exists(key) ? mem[key] : '0;
        end
      end
      if (rsp_valid)
        chk(!p_cas && dram_cas_n && cas_lo == T_CAS, "R8", "column low cycles at response", cas_lo, T_CAS);
      if (req_ready) begin
        chk(dram_cas_n, "R10", "ready with column strobe low", dram_cas_n, 1);
        if (!seen_ready) begin
          seen_ready = 1'b1;
          chk(n_ref >= N_INIT, "R2", "refreshes before ready", n_ref, N_INIT);
        end
      end
      if (dram_ras_n) ras_hi = p_ras ? ras_hi + 1 : 1; else ras_lo = !p_ras ? ras_lo + 1 : 1;
      if (dram_cas_n) cas_hi = p_cas ? cas_hi + 1 : 1; else cas_lo = !p_cas ? cas_lo + 1 : 1;
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", wd, 150000);
      summary();
    end
  end

  task automatic issue(input bit wr, input int a, input logic [DATA_W-1:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = (2*MA_W)'(a);
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc_q.push_back(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input int a);
    int w = 0;
    issue(1'b0, a, '0);
    while (!rsp_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(rsp_valid, "R8", "response arrived", rsp_valid, 1);
    chk(rsp_rdata == expv[a], "R8", $sformatf("read data at %0d", a), rsp_rdata, expv[a]);
  endtask

  initial begin
    int a0, r0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n, "R1", "ras_n/cas_n in reset", {dram_ras_n, dram_cas_n}, 2'b11);
    chk(dram_we_n && dram_oe_n, "R1", "we_n/oe_n in reset", {dram_we_n, dram_oe_n}, 2'b11);
    chk(!dram_dq_oe, "R1", "bus enable in reset", dram_dq_oe, 0);
    chk(!req_ready && !rsp_valid, "R1", "ready/valid in reset", {req_ready, rsp_valid}, 0);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);

    // R9 page hits, R7 early writes: row-major write sweep
    for (int r = 0; r < NC; r++) begin
      a0 = n_act; r0 = n_ref;
      for (int c = 0; c < NC; c++) begin
        expv[r*NC+c] = pat(r*NC+c, 0);
        issue(1'b1, r*NC+c, expv[r*NC+c]);
      end
      @(negedge clk);
      chk(n_act - a0 <= 1 + n_ref - r0, "R9", "activations in same-row burst", n_act - a0, 1 + n_ref - r0);
      chk(n_act - a0 >= 1, "R9", "row opened for burst", n_act - a0, 1);
    end

    // R9 misses: column-major reads change row every access
    a0 = n_act;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NC; r++) rd(r*NC+c);
    @(negedge clk);
    chk(n_act - a0 == NW, "R9", "activations for all-miss sweep", n_act - a0, NW);

    // R6 long same-row run must be split
    a0 = n_act;
    for (int i = 0; i < 2*NC; i++) begin
      expv[5*NC + i%NC] = pat(5*NC + i%NC, i + 1);
      issue(1'b1, 5*NC + i%NC, expv[5*NC + i%NC]);
    end
    @(negedge clk);
    chk(n_act - a0 >= 2, "R6", "page closed by low-time limit", n_act - a0, 2);

    // R8 reads in page mode, row-major
    for (int r = 0; r < NC; r++) begin
      a0 = n_act; r0 = n_ref;
      for (int c = 0; c < NC; c++) rd(r*NC+c);
      @(negedge clk);
      chk(n_act - a0 <= 1 + n_ref - r0, "R9", "activations in read burst", n_act - a0, 1 + n_ref - r0);
    end

    repeat (2 * REF_BOUND) @(negedge clk);
    chk(cyc - last_ref <= REF_BOUND, "R4", "time since last refresh", cyc - last_ref, REF_BOUND);
    chk(acc_q.size() == 0, "R5", "accepted requests left unserved", acc_q.size(), 0);
    summary();
  end
endmodule